// File: doc/BRIEF.md
# Scanned Digit Segment Formatter

This block turns the digit being scanned on a multiplexed dot-matrix fluorescent display into anode drive data. The scan sequencer asks for a digit index one slot early. The block then reads that digit's character code from a 16-entry code store, adding a rotating display-shift offset to the index first. If the code falls in the low user range, the 5-column by 7-row pattern comes from an on-block user pattern store. Otherwise the pattern comes from an external character ROM through a registered read port. The five 7-bit columns are placed side by side on 35 segment outputs.

A separate per-digit symbol byte goes straight onto eight symbol outputs, without any pattern lookup and without the shift offset. Two 16-bit blink masks, one for the segment area and one for the symbol area, darken the selected digits while the external blink square wave is low. Memory and mask writes reach the block already decoded from the host command stream.

Top module: `vfd_digit_formatter`

## Requirements
- R1: A `fetch_req` sampled at clock edge k for digit d makes `out_digit`=d and sets `seg_out` and `sym_out` for d after edge k+2. The outputs hold until a later fetch replaces them.
- R2: The code store is read at address (d + offset) mod 16. The offset is 0 after reset.
- R3: A code from 0x00 to 0x1F selects user pattern entry code[4:0]. Column c (0..4) of that entry drives `seg_out[7c+6:7c]`.
- R4: A code of 0x20 or above appears on `rom_addr` after edge k+1. The ROM answers one cycle later, and `seg_out` then equals `rom_data`.
- R5: `sym_out` equals the symbol byte stored for digit d itself, whatever the shift offset is.
- R6: `shift_left` adds 1 to the offset modulo 16, `shift_right` subtracts 1, and `shift_home` sets it to 0. When more than one is asserted, home wins over left, and left wins over right.
- R7: `blk_we` writes `blk_mask` to the segment mask when `blk_area`=0 and to the symbol mask when `blk_area`=1. Bit n of a mask selects digit n. When the displayed digit is selected in a mask and `blink_in` is low, that area's outputs are all 0. When `blink_in` is high, they show their data. The two areas are independent.
- R8: Reset clears both blink masks, so no digit blinks. Reset also clears the offset and holds `seg_out` and `sym_out` at 0 until the first fetch completes.
- R9: A store write in the same cycle as a fetch that reads that entry returns the old contents. A shift command in the same cycle as `fetch_req` takes effect only from the next fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Start fetch of a digit |
| fetch_digit | input | 4 | Digit index to fetch |
| code_we | input | 1 | Code store write enable |
| code_waddr | input | 4 | Code store write address |
| code_wdata | input | 8 | Character code to store |
| pat_we | input | 1 | User pattern write enable |
| pat_wsel | input | 5 | User pattern entry |
| pat_wcol | input | 3 | Column 0..4 within entry |
| pat_wdata | input | 7 | Column dots |
| sym_we | input | 1 | Symbol store write enable |
| sym_waddr | input | 4 | Symbol store digit |
| sym_wdata | input | 8 | Symbol byte |
| shift_left | input | 1 | Offset +1 |
| shift_right | input | 1 | Offset -1 |
| shift_home | input | 1 | Offset to 0 |
| blk_we | input | 1 | Blink mask write enable |
| blk_area | input | 1 | 0 segment mask, 1 symbol mask |
| blk_mask | input | 16 | Blink mask value |
| blink_in | input | 1 | External blink square wave |
| rom_addr | output | 8 | Character ROM address |
| rom_data | input | 35 | Character ROM pattern, one cycle after address |
| seg_out | output | 35 | Segment drive |
| sym_out | output | 8 | Symbol drive |
| out_digit | output | 4 | Digit shown on outputs |

## Verification
Two kinds of activity can land on the same edge: a host-side update and the fetch it affects. The first case is a code store write to the very entry being read. The second is a shift command arriving in the same cycle as `fetch_req`. The bench drives each pair on one clock edge and expects the old code and the old offset. It then fetches again and expects the new value, so the design must show both the before and the after states.

// File: rtl/vfd_digit_formatter.sv
module vfd_digit_formatter #(
  parameter int DIGITS     = 16,
  parameter int CODE_W     = 8,
  parameter int USER_CODES = 32,
  parameter int COLS       = 5,
  parameter int ROWS       = 7,
  parameter int SYM_W      = 8,
  localparam int DIG_W = $clog2(DIGITS),
  localparam int UC_W  = $clog2(USER_CODES),
  localparam int COL_W = $clog2(COLS),
  localparam int SEG_W = COLS * ROWS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic [DIG_W-1:0]  fetch_digit,
  input  logic              code_we,
  input  logic [DIG_W-1:0]  code_waddr,
  input  logic [CODE_W-1:0] code_wdata,
  input  logic              pat_we,
  input  logic [UC_W-1:0]   pat_wsel,
  input  logic [COL_W-1:0]  pat_wcol,
  input  logic [ROWS-1:0]   pat_wdata,
  input  logic              sym_we,
  input  logic [DIG_W-1:0]  sym_waddr,
  input  logic [SYM_W-1:0]  sym_wdata,
  input  logic              shift_left,
  input  logic              shift_right,
  input  logic              shift_home,
  input  logic              blk_we,
  input  logic              blk_area,
  input  logic [DIGITS-1:0] blk_mask,
  input  logic              blink_in,
  output logic [CODE_W-1:0] rom_addr,
  input  logic [SEG_W-1:0]  rom_data,
  output logic [SEG_W-1:0]  seg_out,
  output logic [SYM_W-1:0]  sym_out,
  output logic [DIG_W-1:0]  out_digit
);

  logic [CODE_W-1:0] code_ram [DIGITS];
  logic [SYM_W-1:0]  sym_ram  [DIGITS];
  logic [ROWS-1:0]   pat_ram  [USER_CODES][COLS];

  logic [DIG_W-1:0]  offs, rd_addr, dig1, dig2;
  logic [CODE_W-1:0] code_q;
  logic              valid1, user_q;
  logic [SEG_W-1:0]  pat_q, pat_sel;
  logic [SYM_W-1:0]  sym_q;
  logic [DIGITS-1:0] mask_seg, mask_sym;

  assign rd_addr = fetch_digit + offs;

  always_ff @(posedge clk) begin
    if (code_we) code_ram[code_waddr] <= code_wdata;
    if (sym_we) sym_ram[sym_waddr] <= sym_wdata;
    if (pat_we && pat_wcol < COL_W'(COLS)) pat_ram[pat_wsel][pat_wcol] <= pat_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      offs     <= '0;
      mask_seg <= '0;
      mask_sym <= '0;
    end else begin
      if (shift_home)       offs <= '0;
      else if (shift_left)  offs <= offs + 1'b1;
      else if (shift_right) offs <= offs - 1'b1;
      if (blk_we) begin
        if (blk_area) mask_sym <= blk_mask;
        else          mask_seg <= blk_mask;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid1 <= 1'b0;
      code_q <= '0;
      dig1   <= '0;
      dig2   <= '0;
      user_q <= 1'b1;
      pat_q  <= '0;
      sym_q  <= '0;
    end else begin
      valid1 <= fetch_req;
      if (fetch_req) begin
        code_q <= code_ram[rd_addr];
        dig1   <= fetch_digit;
      end
      if (valid1) begin
        user_q <= code_q < CODE_W'(USER_CODES);
        sym_q  <= sym_ram[dig1];
        dig2   <= dig1;
        for (int c = 0; c < COLS; c++)
          pat_q[c*ROWS +: ROWS] <= pat_ram[code_q[UC_W-1:0]][c];
      end
    end
  end

  assign rom_addr  = code_q;
  assign pat_sel   = user_q ? pat_q : rom_data;
  assign seg_out   = (mask_seg[dig2] && !blink_in) ? '0 : pat_sel;
  assign sym_out   = (mask_sym[dig2] && !blink_in) ? '0 : sym_q;
  assign out_digit = dig2;

endmodule

// File: rtl/vfd_digit_formatter_chk.sv
module vfd_digit_formatter_chk #(
  parameter int DIGITS = 16,
  parameter int SEG_W  = 35,
  parameter int SYM_W  = 8,
  localparam int DIG_W = $clog2(DIGITS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_req,
  input logic [DIG_W-1:0]  fetch_digit,
  input logic              blk_we,
  input logic              blk_area,
  input logic [DIGITS-1:0] blk_mask,
  input logic              blink_in,
  input logic [SEG_W-1:0]  seg_out,
  input logic [SYM_W-1:0]  sym_out,
  input logic [DIG_W-1:0]  out_digit
);

  logic [DIGITS-1:0] sh_seg, sh_sym;
  logic [1:0]        up_cnt;
  logic              seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_seg <= '0;
      sh_sym <= '0;
      up_cnt <= '0;
      seen   <= 1'b0;
    end else begin
      if (up_cnt != 2'd2) up_cnt <= up_cnt + 1'b1;
      if (fetch_req) seen <= 1'b1;
      if (blk_we) begin
        if (blk_area) sh_sym <= blk_mask;
        else          sh_seg <= blk_mask;
      end
    end
  end

  assert_seg_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!blink_in && sh_seg[out_digit]) |-> seg_out == '0);

  assert_sym_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!blink_in && sh_sym[out_digit]) |-> sym_out == '0);

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> ##2 (out_digit == $past(fetch_digit, 2)));

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt == 2'd2 && !$past(fetch_req, 2) && !$past(blk_we) && $stable(blink_in))
      |-> $stable(sym_out));

  assert_quiet_after_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> (seg_out == '0 && sym_out == '0));

endmodule

bind vfd_digit_formatter vfd_digit_formatter_chk #(
  .DIGITS(DIGITS), .SEG_W(COLS * ROWS), .SYM_W(SYM_W)
) u_chk (.*);

// File: tb/vfd_digit_formatter_tb.sv
module vfd_digit_formatter_tb;
  logic clk = 0, rst_n = 0;
  logic fetch_req = 0; logic [3:0] fetch_digit = 0;
  logic code_we = 0; logic [3:0] code_waddr = 0; logic [7:0] code_wdata = 0;
  logic pat_we = 0; logic [4:0] pat_wsel = 0; logic [2:0] pat_wcol = 0; logic [6:0] pat_wdata = 0;
  logic sym_we = 0; logic [3:0] sym_waddr = 0; logic [7:0] sym_wdata = 0;
  logic shift_left = 0, shift_right = 0, shift_home = 0;
  logic blk_we = 0, blk_area = 0; logic [15:0] blk_mask = 0;
  logic blink_in = 0;
  logic [7:0] rom_addr; logic [34:0] rom_data = 0;
  logic [34:0] seg_out; logic [7:0] sym_out; logic [3:0] out_digit;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] code_m [16];
  logic [7:0] sym_m [16];
  logic [6:0] pat_m [32][5];
  logic [34:0] held;

  // {op[1:0] (0 none,1 left,2 right,3 home), digit[3:0], expected code address[3:0]}
  localparam logic [9:0] TBL [11] = '{
    {2'd0, 4'd0, 4'd0},  {2'd0, 4'd5, 4'd5},  {2'd1, 4'd0, 4'd1},
    {2'd1, 4'd15, 4'd1}, {2'd2, 4'd3, 4'd4},  {2'd3, 4'd7, 4'd7},
    {2'd2, 4'd0, 4'd15}, {2'd2, 4'd1, 4'd15}, {2'd3, 4'd9, 4'd9},
    {2'd2, 4'd15, 4'd14},{2'd3, 4'd12, 4'd12}};

  always #5 clk = ~clk;

  vfd_digit_formatter u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_digit(fetch_digit),
    .code_we(code_we), .code_waddr(code_waddr), .code_wdata(code_wdata),
    .pat_we(pat_we), .pat_wsel(pat_wsel), .pat_wcol(pat_wcol), .pat_wdata(pat_wdata),
    .sym_we(sym_we), .sym_waddr(sym_waddr), .sym_wdata(sym_wdata),
    .shift_left(shift_left), .shift_right(shift_right), .shift_home(shift_home),
    .blk_we(blk_we), .blk_area(blk_area), .blk_mask(blk_mask), .blink_in(blink_in),
    .rom_addr(rom_addr), .rom_data(rom_data),
    .seg_out(seg_out), .sym_out(sym_out), .out_digit(out_digit));

  function automatic logic [34:0] rom_fn(input logic [7:0] a);
    return {a[6:0], ~a[6:0], a[6:0] ^ 7'h2A, a[6:0] + 7'd3, {a[0], a[7:2]}};
  endfunction

  always_ff @(posedge clk) rom_data <= rom_fn(rom_addr);

  function automatic logic [34:0] exp_seg(input logic [7:0] code);
    logic [34:0] r;
    if (code < 8'h20) begin
      for (int c = 0; c < 5; c++) r[c*7 +: 7] = pat_m[code[4:0]][c];
      return r;
    end
    return rom_fn(code);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_code(input int a, input logic [7:0] d);
    @(negedge clk); code_we = 1; code_waddr = 4'(a); code_wdata = d;
    @(negedge clk); code_we = 0;
    code_m[a] = d;
  endtask

  task automatic shift(input logic [1:0] op);
    @(negedge clk);
    shift_left = (op == 2'd1); shift_right = (op == 2'd2); shift_home = (op == 2'd3);
    @(negedge clk); shift_left = 0; shift_right = 0; shift_home = 0;
  endtask

  task automatic fetch(input int d);
    @(negedge clk); fetch_req = 1; fetch_digit = 4'(d);
    @(negedge clk); fetch_req = 0;
    @(negedge clk);
  endtask

  task automatic set_mask(input logic area, input logic [15:0] m);
    @(negedge clk); blk_we = 1; blk_area = area; blk_mask = m;
    @(negedge clk); blk_we = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 16; a++) begin
      code_m[a] = (a % 2 == 1) ? 8'(64 + a * 5) : 8'(a * 2);
      sym_m[a]  = 8'(a * 37 + 1);
    end
    for (int e = 0; e < 32; e++)
      for (int c = 0; c < 5; c++) pat_m[e][c] = 7'((e * 13 + c * 29 + 5) % 128);

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R8 reset seg", 64'(seg_out), 64'h0);
    check("R8 reset sym", 64'(sym_out), 64'h0);

    for (int a = 0; a < 16; a++) begin
      wr_code(a, code_m[a]);
      @(negedge clk); sym_we = 1; sym_waddr = 4'(a); sym_wdata = sym_m[a];
      @(negedge clk); sym_we = 0;
    end
    for (int e = 0; e < 32; e++)
      for (int c = 0; c < 5; c++) begin
        @(negedge clk); pat_we = 1; pat_wsel = 5'(e); pat_wcol = 3'(c); pat_wdata = pat_m[e][c];
        @(negedge clk); pat_we = 0;
      end

    // blink_in stays low here: with masks cleared by reset nothing may go dark (R8)
    for (int i = 0; i < 11; i++) begin
      if (TBL[i][9:8] != 2'd0) shift(TBL[i][9:8]);
      fetch(int'(TBL[i][7:4]));
      check("R2 R8 seg via shifted address", 64'(seg_out), 64'(exp_seg(code_m[TBL[i][3:0]])));
      check("R5 sym unshifted", 64'(sym_out), 64'(sym_m[TBL[i][7:4]]));
      check("R1 out_digit", 64'(out_digit), 64'(TBL[i][7:4]));
    end

    wr_code(3, 8'h1F);
    fetch(3);
    check("R3 code 0x1F user entry", 64'(seg_out), 64'(exp_seg(8'h1F)));
    wr_code(3, 8'h20);
    @(negedge clk); fetch_req = 1; fetch_digit = 4'd3;
    @(negedge clk); fetch_req = 0;
    check("R4 rom_addr", 64'(rom_addr), 64'h20);
    @(negedge clk);
    check("R4 code 0x20 from rom", 64'(seg_out), 64'(rom_fn(8'h20)));
    held = seg_out;
    repeat (5) @(negedge clk);
    check("R1 hold seg", 64'(seg_out), 64'(held));
    check("R1 hold digit", 64'(out_digit), 64'd3);

    @(negedge clk); shift_left = 1; shift_right = 1;
    @(negedge clk); shift_left = 0; shift_right = 0;
    fetch(0);
    check("R6 left beats right", 64'(seg_out), 64'(exp_seg(code_m[1])));
    @(negedge clk); shift_home = 1; shift_left = 1;
    @(negedge clk); shift_home = 0; shift_left = 0;
    fetch(6);
    check("R6 home beats left", 64'(seg_out), 64'(exp_seg(code_m[6])));

    set_mask(1'b0, 16'h0040);
    @(negedge clk);
    check("R7 seg dark while low", 64'(seg_out), 64'h0);
    check("R7 sym area unaffected", 64'(sym_out), 64'(sym_m[6]));
    @(negedge clk); blink_in = 1; #1;
    check("R7 seg lit while high", 64'(seg_out), 64'(exp_seg(code_m[6])));
    @(negedge clk); blink_in = 0;
    set_mask(1'b1, 16'h0040);
    @(negedge clk);
    check("R7 sym dark while low", 64'(sym_out), 64'h0);
    fetch(7);
    check("R7 unmasked digit seg", 64'(seg_out), 64'(exp_seg(code_m[7])));
    check("R7 unmasked digit sym", 64'(sym_out), 64'(sym_m[7]));
    set_mask(1'b0, 16'h0000);
    set_mask(1'b1, 16'h0000);

    @(negedge clk); fetch_req = 1; fetch_digit = 4'd2; code_we = 1; code_waddr = 4'd2; code_wdata = 8'h77;
    @(negedge clk); fetch_req = 0; code_we = 0;
    @(negedge clk);
    check("R9 same-cycle write gives old code", 64'(seg_out), 64'(exp_seg(code_m[2])));
    code_m[2] = 8'h77;
    fetch(2);
    check("R9 later fetch gives new code", 64'(seg_out), 64'(rom_fn(8'h77)));

    @(negedge clk); fetch_req = 1; fetch_digit = 4'd4; shift_left = 1;
    @(negedge clk); fetch_req = 0; shift_left = 0;
    @(negedge clk);
    check("R9 shift with fetch uses old offset", 64'(seg_out), 64'(exp_seg(code_m[4])));
    fetch(4);
    check("R9 next fetch uses new offset", 64'(seg_out), 64'(exp_seg(code_m[5])));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule